// File: doc/BRIEF.md
# Value Cache Bus Decoder

This block sits at the receiving end of a link that saves bus switching by caching recently sent words on both sides. Each transferred word comes with a flag. When the flag is low the bus carries a full data word. The decoder returns that word and writes it into its own table. When the flag is high the bus carries a one-hot pointer to a table slot. The decoder returns the word stored in that slot.

The table has one slot per bus line, and each slot holds a full word. The sender keeps an identical table. The two tables stay equal only because both sides apply the same fill order, the same usage tracking and the same eviction choice to every accepted word. That tracking is the same whichever direction the word travelled, so a word written by one transfer can be pointed to by a later transfer in the opposite direction. A pointer that is not exactly one-hot, or that names an empty slot, is flagged as a protocol error. Such a word leaves all table state untouched.

The eviction choice works as follows:
- Each slot has a recently-used bit and an age history of `TS_W` bits.
- Every `AGE_PERIOD` accepted words, each slot's used bit shifts into the top of its history and the used bit is cleared.
- When no slot is empty, the victim is the slot with the lowest {used bit, history} value.

Top module: `vcd_decoder`

## Requirements
- R1: After reset, out_valid and out_err are low and every table slot is empty, so any pointer word is reported as an error.
- R2: A raw word (in_valid high, in_is_index low) appears unchanged on out_data with out_valid high exactly one clock later, and out_err low.
- R3: A pointer word with only bit k of in_bus set, where slot k holds data, yields slot k's stored word on out_data with out_valid high one clock later.
- R4: While any slot is empty, a raw word is stored in the lowest-numbered empty slot; a filled slot never becomes empty again.
- R5: When all slots are full, a raw word replaces the slot whose {used bit, history} value is smallest, the lowest slot number winning ties.
- R6: Every accepted word, pointer or raw, sets the used bit of the slot it touches; a newly stored word starts with its used bit set and a zero history.
- R7: On every AGE_PERIOD-th accepted word, after that word's own update, each slot's used bit moves into the top bit of its history, the history shifts down one place dropping its lowest bit, and all used bits clear.
- R8: A pointer word with zero or more than one bit set gives out_err high and out_valid low one clock later and changes no table state or aging count.
- R9: A one-hot pointer to an empty slot gives out_err high and out_valid low one clock later and changes no state.
- R10: A cycle with in_valid low gives neither out_valid nor out_err on the next clock and changes no state, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is present on the bus this cycle |
| in_is_index | input | 1 | High: in_bus is a one-hot slot pointer; low: in_bus is raw data |
| in_bus | input | W | Bus lines |
| out_valid | output | 1 | out_data holds a rebuilt word |
| out_data | output | W | Rebuilt data word |
| out_err | output | 1 | The previous word was a malformed or dangling pointer |

## Verification
The bench aims at the eviction choice. It fills the table, ages it, and then touches chosen slots so that the correct victim differs from the one a design would pick if it ignored used bits (R6) or never aged (R7). A wrong design writes the new word into another slot, and the pointer probe that follows returns the wrong data. Malformed pointers are sent between normal words, including the all-zero pointer, multi-bit pointers and pointers to empty slots. A design that let them touch used bits or the aging count would drift out of step, and later random pointer lookups would return stale words. Idle cycles carry garbage on the bus to show that nothing is emitted or stored.

// File: rtl/vcd_pkg.sv
package vcd_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_RAW  = 2'd1,
    KIND_HIT  = 2'd2,
    KIND_BAD  = 2'd3
  } word_kind_e;

  // index width that is never zero
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/vcd_classify.sv
module vcd_classify
  import vcd_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 5
) (
  input  logic          in_valid,
  input  logic          in_is_index,
  input  logic [W-1:0]  in_bus,
  input  logic [W-1:0]  valid_vec,
  output word_kind_e    kind,
  output logic [IW-1:0] hit_slot
);

  function automatic logic is_onehot(input logic [W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < W; i++) n += v[i] ? 1 : 0;
    return n == 1;
  endfunction

  function automatic logic [IW-1:0] onehot_to_idx(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) if (v[i]) r = r | IW'(i);
    return r;
  endfunction

  always_comb begin
    hit_slot = onehot_to_idx(in_bus);
    if (!in_valid)                                          kind = KIND_NONE;
    else if (!in_is_index)                                  kind = KIND_RAW;
    else if (!is_onehot(in_bus) || ((in_bus & valid_vec) == '0)) kind = KIND_BAD;
    else                                                    kind = KIND_HIT;
  end

endmodule

// File: rtl/vcd_repl.sv
module vcd_repl #(
  parameter int unsigned W    = 32,
  parameter int unsigned IW   = 5,
  parameter int unsigned TS_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic          insert,
  input  logic [IW-1:0] slot,
  input  logic          age,
  output logic [IW-1:0] victim,
  output logic [W-1:0]  valid_vec
);

  localparam int unsigned KW = TS_W + 1;

  logic [W-1:0]    used_q, used_d, valid_d;
  logic [TS_W-1:0] hist_q [W];
  logic [TS_W-1:0] hist_d [W];

  // victim: lowest empty slot, else smallest {used, history}, lowest index on ties
  always_comb begin
    logic          found_free;
    logic [IW-1:0] free_idx, best_idx;
    logic [KW-1:0] best_key, key;
    found_free = 1'b0;
    free_idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        found_free = 1'b1;
        free_idx   = IW'(i);
      end
    end
    best_idx = '0;
    best_key = {used_q[0], hist_q[0]};
    for (int i = 1; i < W; i++) begin
      key = {used_q[i], hist_q[i]};
      if (key < best_key) begin
        best_key = key;
        best_idx = IW'(i);
      end
    end
    victim = found_free ? free_idx : best_idx;
  end

  always_comb begin
    logic            u;
    logic [TS_W-1:0] h;
    valid_d = valid_vec;
    for (int i = 0; i < W; i++) begin
      u = used_q[i];
      h = hist_q[i];
      if (touch && (slot == IW'(i))) begin
        u = 1'b1;
        if (insert) begin
          h          = '0;
          valid_d[i] = 1'b1;
        end
      end
      if (age) begin
        h = {u, h[TS_W-1:1]};
        u = 1'b0;
      end
      used_d[i] = u;
      hist_d[i] = h;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_vec <= '0;
      used_q    <= '0;
      for (int i = 0; i < W; i++) hist_q[i] <= '0;
    end else begin
      valid_vec <= valid_d;
      used_q    <= used_d;
      for (int i = 0; i < W; i++) hist_q[i] <= hist_d[i];
    end
  end

endmodule

// File: rtl/vcd_store.sv
module vcd_store #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wslot,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] rslot,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [W];

  always_ff @(posedge clk) begin
    if (we) mem[wslot] <= wdata;
  end

  assign rdata = mem[rslot];

endmodule

// File: rtl/vcd_decoder.sv
module vcd_decoder
  import vcd_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned TS_W       = 3,
  parameter int unsigned AGE_PERIOD = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_is_index,
  input  logic [W-1:0] in_bus,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_err
);

  localparam int unsigned IW = idx_width(W);
  localparam int unsigned CW = idx_width(AGE_PERIOD);

  word_kind_e    kind;
  logic [IW-1:0] hit_slot, victim, slot_sel;
  logic [W-1:0]  valid_vec, rd_data;
  logic          accept, is_raw, age_tick;
  logic [CW-1:0] age_cnt;

  vcd_classify #(.W(W), .IW(IW)) u_class (
    .in_valid   (in_valid),
    .in_is_index(in_is_index),
    .in_bus     (in_bus),
    .valid_vec  (valid_vec),
    .kind       (kind),
    .hit_slot   (hit_slot)
  );

  assign is_raw   = (kind == KIND_RAW);
  assign accept   = is_raw || (kind == KIND_HIT);
  assign slot_sel = is_raw ? victim : hit_slot;
  assign age_tick = accept && (age_cnt == CW'(AGE_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        age_cnt <= '0;
    else if (age_tick) age_cnt <= '0;
    else if (accept)   age_cnt <= age_cnt + 1'b1;
  end

  vcd_repl #(.W(W), .IW(IW), .TS_W(TS_W)) u_repl (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch    (accept),
    .insert   (is_raw),
    .slot     (slot_sel),
    .age      (age_tick),
    .victim   (victim),
    .valid_vec(valid_vec)
  );

  vcd_store #(.W(W), .IW(IW)) u_store (
    .clk  (clk),
    .we   (is_raw),
    .wslot(victim),
    .wdata(in_bus),
    .rslot(hit_slot),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= accept;
      out_err   <= (kind == KIND_BAD);
      if (accept) out_data <= is_raw ? in_bus : rd_data;
    end
  end

endmodule

// File: rtl/vcd_decoder_chk.sv
module vcd_decoder_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_is_index,
  input logic [W-1:0] in_bus,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_err,
  input logic [W-1:0] valid_vec
);

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));

  assert_raw_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_index) |=> (out_valid && !out_err && out_data == $past(in_bus)));

  assert_bad_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_index && $countones(in_bus) != 1) |=> (out_err && !out_valid));

  assert_dangling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_index && $onehot(in_bus) && ((in_bus & valid_vec) == '0))
      |=> (out_err && !out_valid && $stable(valid_vec)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_err && $stable(valid_vec)));

  assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_index && !(&valid_vec))
      |=> ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

  assert_no_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(valid_vec) & ~valid_vec) == '0));

endmodule

bind vcd_decoder vcd_decoder_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_is_index(in_is_index),
  .in_bus     (in_bus),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_err    (out_err),
  .valid_vec  (valid_vec)
);

// File: tb/vcd_decoder_tb.sv
module vcd_decoder_tb;

  localparam int unsigned W    = 32;
  localparam int unsigned TS_W = 3;
  localparam int unsigned AGEP = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_is_index = 1'b0;
  logic [W-1:0] in_bus = '0;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_err;

  int n_cmp = 0;
  int n_bad = 0;

  logic [W-1:0] m_data [W];
  bit           m_valid [W];
  bit           m_used [W];
  int unsigned  m_hist [W];
  int unsigned  m_cnt;

  always #10 clk = ~clk;

  vcd_decoder #(.W(W), .TS_W(TS_W), .AGE_PERIOD(AGEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_index(in_is_index),
    .in_bus(in_bus), .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  function automatic int model_victim();
    int best, bkey, key;
    for (int i = 0; i < W; i++) if (!m_valid[i]) return i;
    best = 0;
    bkey = (int'(m_used[0]) << TS_W) + int'(m_hist[0]);
    for (int i = 1; i < W; i++) begin
      key = (int'(m_used[i]) << TS_W) + int'(m_hist[i]);
      if (key < bkey) begin bkey = key; best = i; end
    end
    return best;
  endfunction

  function automatic void model_apply(int slot, bit raw, logic [W-1:0] d);
    m_used[slot] = 1'b1;
    if (raw) begin
      m_data[slot] = d; m_valid[slot] = 1'b1; m_hist[slot] = 0;
    end
    if (m_cnt == AGEP - 1) begin
      for (int i = 0; i < W; i++) begin
        m_hist[i] = (m_hist[i] >> 1) | (int'(m_used[i]) << (TS_W - 1));
        m_used[i] = 1'b0;
      end
      m_cnt = 0;
    end else m_cnt++;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < W; i++) begin
      m_valid[i] = 0; m_used[i] = 0; m_hist[i] = 0; m_data[i] = '0;
    end
    m_cnt = 0;
  endfunction

  task automatic check(string tag, bit ev, bit ee, logic [W-1:0] ed);
    n_cmp++;
    if (out_valid !== ev || out_err !== ee || (ev && out_data !== ed)) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b err=%0b data=%h, expected valid=%0b err=%0b data=%h",
               tag, out_valid, out_err, out_data, ev, ee, ed);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic xfer(bit idx, logic [W-1:0] bus, string tag);
    bit ev, ee;
    logic [W-1:0] ed;
    int k;
    ev = 0; ee = 0; ed = '0; k = 0;
    if (!idx) begin
      ev = 1; ed = bus;
      model_apply(model_victim(), 1'b1, bus);
    end else if ($countones(bus) != 1) begin
      ee = 1;
    end else begin
      for (int i = 0; i < W; i++) if (bus[i]) k = i;
      if (!m_valid[k]) ee = 1;
      else begin
        ev = 1; ed = m_data[k];
        model_apply(k, 1'b0, '0);
      end
    end
    in_valid = 1'b1; in_is_index = idx; in_bus = bus;
    @(negedge clk);
    check(tag, ev, ee, ed);
    in_valid = 1'b0;
  endtask

  task automatic idle(logic [W-1:0] junk, string tag);
    in_valid = 1'b0; in_is_index = junk[0]; in_bus = junk;
    @(negedge clk);
    check(tag, 1'b0, 1'b0, '0);
  endtask

  function automatic logic [W-1:0] ptr(int k);
    logic [W-1:0] v;
    v = '0; v[k] = 1'b1;
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic fill_all(logic [W-1:0] base);
    for (int i = 0; i < W; i++) xfer(1'b0, base + W'(i), "R4 fill");
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pool [16];
    void'($urandom(32'd7321));
    model_reset();
    @(negedge clk);
    do_reset();

    // R1: reset state and empty table
    check("R1 reset outputs", 1'b0, 1'b0, '0);
    xfer(1'b1, ptr(0), "R1 empty table pointer");
    // R9 dangling pointer, R8 malformed pointers
    xfer(1'b1, ptr(W - 1), "R9 dangling pointer");
    xfer(1'b1, '0, "R8 zero pointer");
    // R2 / R4: fill order
    xfer(1'b0, 32'hDEAD_0001, "R2 raw pass");
    xfer(1'b0, 32'hDEAD_0002, "R2 raw pass");
    xfer(1'b1, ptr(0), "R4 first slot");
    xfer(1'b1, 32'h0000_0003, "R8 two-bit pointer");
    xfer(1'b1, ptr(1), "R4 second slot");
    idle(32'hFFFF_FFFF, "R10 idle junk");
    xfer(1'b1, ptr(2), "R9 next empty slot");

    // R6 scenario: fill, touch slot 0, insert -> victim must skip slot 0
    do_reset();
    fill_all(32'h1000_0000);
    xfer(1'b1, ptr(0), "R3 hit after fill");
    xfer(1'b0, 32'hCAFE_0006, "R2 raw into full table");
    xfer(1'b1, ptr(1), "R6 used bit protects slot 0");
    xfer(1'b1, ptr(0), "R3 slot 0 kept");

    // R7 scenario: fill, touch slots 0..7 (ages on the 8th), insert -> slot 8
    do_reset();
    fill_all(32'h2000_0000);
    for (int i = 0; i < 8; i++) xfer(1'b1, ptr(i), "R3 touch");
    xfer(1'b0, 32'hBEEF_0007, "R2 raw after aging");
    xfer(1'b1, ptr(8), "R7 aged history picks slot 8");
    // R5: next victim is the following oldest slot
    xfer(1'b0, 32'hBEEF_0005, "R2 raw");
    xfer(1'b1, ptr(9), "R5 next victim");
    xfer(1'b1, 32'hFFFF_FFFF, "R8 all-ones pointer");
    xfer(1'b1, ptr(8), "R5 earlier insert kept");

    // random phase
    do_reset();
    for (int i = 0; i < 16; i++) pool[i] = $urandom;
    for (int n = 0; n < 3000; n++) begin
      int r, k;
      r = $urandom % 100;
      if (r < 40) xfer(1'b0, pool[$urandom % 16] ^ W'($urandom % 64), "R2/R5 random raw");
      else if (r < 85) begin
        k = $urandom % W;
        if (!m_valid[k]) xfer(1'b1, ptr(k), "R9 random dangling");
        else xfer(1'b1, ptr(k), "R3 random hit");
      end else if (r < 92) xfer(1'b1, ptr($urandom % W) | ptr($urandom % W) ^ ptr(0), "R8 random malformed");
      else idle($urandom, "R10 random idle");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule